// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a quad-bank single-data-rate SDRAM from reset to a usable state. It drives the command pins, the bank select and the 13-bit address bus. After reset it holds chip select inactive until an external input reports that the clock is stable. It then issues only NOP commands for a long, parameterized power-up interval. After that interval it precharges every bank, issues a parameterized number of auto-refresh commands (never fewer than eight), and loads the mode register. The mode word is built from parameters for burst length, burst ordering and CAS latency.

Each command is separated from the next by a programmable gap of NOP cycles, one gap for each timing constraint. When the gap after the mode load has elapsed, the sequencer raises a ready flag. It then parks on NOP until the next reset, and the controller that owns normal traffic can take over the bus.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until `clk_stable` is sampled high, the bus carries COMMAND INHIBIT (`cs_n`=1, other command pins 1, address 0). `cke` and `dqm` are 1 and `init_done` is 0.
- R2: From the first rising edge that samples `clk_stable` high, exactly `PWRUP_CYCLES` consecutive cycles of NOP ({cs_n,ras_n,cas_n,we_n}=0111) appear before any other command.
- R3: The first non-NOP command is one cycle of PRECHARGE (0010) with `addr[10]`=1 (all banks) and `ba`=00.
- R4: The first AUTO REFRESH follows the precharge by exactly `TRP_CYCLES` cycles, with NOP in between.
- R5: Exactly max(`REFRESH_COUNT`,8) AUTO REFRESH commands (0001) are issued, `TRFC_CYCLES` cycles apart, with NOP in between.
- R6: LOAD MODE REGISTER (0000) with `ba`=00 is issued once, `TRFC_CYCLES` cycles after the last refresh, and never before all refreshes are issued.
- R7: The mode word on `addr` holds the burst length code in bits 2:0 (1→000, 2→001, 4→010, 8→011), the burst ordering in bit 3 (1 = interleaved), the CAS latency in bits 6:4, and zeros in bits 12:7.
- R8: `init_done` rises exactly `TMRD_CYCLES` cycles after the mode load. It stays high until reset, and the bus carries NOP while it is high.
- R9: Once the sequence has started, `clk_stable` is ignored: dropping it mid-sequence leaves the command timeline unchanged.
- R10: Asserting reset mid-sequence returns the bus to COMMAND INHIBIT with `init_done` low. The next start repeats the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_stable | input | 1 | High once the memory clock and supplies are stable; starts the sequence |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high during initialization |
| ba | output | 2 | Bank select |
| addr | output | 13 | Address bus; carries the all-banks bit and the mode word |
| init_done | output | 1 | Sequence complete, memory ready |

## Verification
The bench records the whole command timeline after start-up and compares every cycle against a schedule worked out from the timing parameters. It therefore catches an off-by-one in the power-up wait or in any gap: such a design would place the precharge, a refresh or the mode load one cycle early or late. The bench counts the refreshes, which catches a sequencer that stops at seven or issues a ninth. It checks the full mode word, which exposes a field shifted by one bit or a wrong burst-length code. It also drops `clk_stable` mid-run, where a design that still watched the input would stall or restart. It resets the block mid-run, where a design that kept its timer or refresh count would skip the long wait on the restart.

// File: rtl/sdram_init_pkg.sv
// Package: shared types and helpers for the SDRAM power-up sequencer.
// Assumes command pins are ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // waiting for clk_stable, COMMAND INHIBIT on bus
        ST_WAIT,    // power-up NOP interval
        ST_PRE,     // precharge all banks
        ST_TRP,     // NOP gap after precharge
        ST_REF,     // one auto refresh
        ST_TRFC,    // NOP gap after a refresh
        ST_MRS,     // mode register load
        ST_TMRD,    // NOP gap after mode load
        ST_DONE     // ready, NOP forever
    } init_state_t;

    localparam logic [3:0] CMD_INHIBIT = 4'b1111;
    localparam logic [3:0] CMD_NOP     = 4'b0111;
    localparam logic [3:0] CMD_PRE     = 4'b0010;
    localparam logic [3:0] CMD_REF     = 4'b0001;
    localparam logic [3:0] CMD_MRS     = 4'b0000;

    // Builds the 13-bit mode word from burst length, ordering and CAS latency.
    function automatic logic [12:0] mode_word(input int bl, input bit interleave, input int cl);
        logic [2:0] bl_code;
        case (bl)
            1:       bl_code = 3'b000;
            2:       bl_code = 3'b001;
            4:       bl_code = 3'b010;
            8:       bl_code = 3'b011;
            default: bl_code = 3'b111;
        endcase
        return {6'b0, cl[2:0], interleave, bl_code};
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Module: down-counter that times the NOP intervals of the sequencer.
// Assumes: load has priority; the count sticks at zero until reloaded.
module sdram_init_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt;

    // Load a new interval or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Expose interval expiry.
    assign zero = (cnt == '0);

    // R2: an expired timer stays expired unless reloaded (no wrap-around).
    a_r2_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

endmodule

// File: rtl/sdram_init_cmd_enc.sv
// Module: maps the sequencer state to SDRAM command, bank and address pins.
// Assumes: purely combinational; bank select is always zero during init.
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter logic [12:0] MODE_VAL = 13'h0
) (
    input  init_state_t state,
    output logic [3:0]  cmd,
    output logic [1:0]  ba,
    output logic [12:0] addr
);

    // Decode state into the pin pattern for this cycle.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'b00;
        addr = '0;
        unique case (state)
            ST_IDLE: cmd = CMD_INHIBIT;
            ST_PRE: begin
                cmd      = CMD_PRE;
                addr[10] = 1'b1;
            end
            ST_REF:  cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE_VAL;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Module: SDRAM power-up sequencer top. Waits, precharges all banks,
// refreshes N times, loads the mode register, then flags ready.
// Assumes: gaps are command-to-command distances in cycles (clamped to >= 2);
// the refresh count is clamped to at least eight.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int PWRUP_CYCLES     = 28600,
    parameter int TRP_CYCLES       = 3,
    parameter int TRFC_CYCLES      = 10,
    parameter int TMRD_CYCLES      = 2,
    parameter int REFRESH_COUNT    = 8,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LATENCY      = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_stable,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic        cke,
    output logic        dqm,
    output logic [1:0]  ba,
    output logic [12:0] addr,
    output logic        init_done
);

    localparam int PWRUP_EFF = (PWRUP_CYCLES < 1) ? 1 : PWRUP_CYCLES;
    localparam int TRP_EFF   = (TRP_CYCLES   < 2) ? 2 : TRP_CYCLES;
    localparam int TRFC_EFF  = (TRFC_CYCLES  < 2) ? 2 : TRFC_CYCLES;
    localparam int TMRD_EFF  = (TMRD_CYCLES  < 2) ? 2 : TMRD_CYCLES;
    localparam int NREF      = (REFRESH_COUNT < 8) ? 8 : REFRESH_COUNT;
    localparam int MAX_A     = (PWRUP_EFF > TRP_EFF) ? PWRUP_EFF : TRP_EFF;
    localparam int MAX_B     = (TRFC_EFF > TMRD_EFF) ? TRFC_EFF : TMRD_EFF;
    localparam int MAX_LOAD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW        = $clog2(MAX_LOAD + 1);
    localparam int RW        = $clog2(NREF + 1);
    localparam logic [12:0] MODE_VAL = mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LATENCY);

    init_state_t   state, state_nx;
    logic [RW-1:0] ref_cnt;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_zero;
    logic [3:0]    cmd;

    sdram_init_timer #(.WIDTH(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sdram_init_cmd_enc #(.MODE_VAL(MODE_VAL)) enc_i (
        .state (state),
        .cmd   (cmd),
        .ba    (ba),
        .addr  (addr)
    );

    // Choose the next step and the interval the timer must run for it.
    always_comb begin
        state_nx = state;
        t_load   = 1'b0;
        t_val    = '0;
        unique case (state)
            ST_IDLE: if (clk_stable) begin
                state_nx = ST_WAIT;
                t_load   = 1'b1;
                t_val    = CW'(PWRUP_EFF - 1);
            end
            ST_WAIT: if (t_zero) state_nx = ST_PRE;
            ST_PRE: begin
                state_nx = ST_TRP;
                t_load   = 1'b1;
                t_val    = CW'(TRP_EFF - 2);
            end
            ST_TRP:  if (t_zero) state_nx = ST_REF;
            ST_REF: begin
                state_nx = ST_TRFC;
                t_load   = 1'b1;
                t_val    = CW'(TRFC_EFF - 2);
            end
            ST_TRFC: if (t_zero) state_nx = (ref_cnt == RW'(NREF)) ? ST_MRS : ST_REF;
            ST_MRS: begin
                state_nx = ST_TMRD;
                t_load   = 1'b1;
                t_val    = CW'(TMRD_EFF - 2);
            end
            ST_TMRD: if (t_zero) state_nx = ST_DONE;
            default: state_nx = ST_DONE;
        endcase
    end

    // Advance the sequence; reset returns to the inhibit state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Count issued refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n)              ref_cnt <= '0;
        else if (state == ST_REF) ref_cnt <= ref_cnt + 1'b1;
    end

    // Drive the pins.
    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = 1'b1;
    assign dqm       = 1'b1;
    assign init_done = (state == ST_DONE);

    // R2: nothing but NOP or INHIBIT before the power-up wait ends.
    a_r2_only_nop_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> (cmd == CMD_NOP || cmd == CMD_INHIBIT));

    // R3: precharge always targets all banks.
    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (addr[10] && ba == 2'b00));

    // R5: refresh count never exceeds the target.
    a_r5_ref_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> (ref_cnt < RW'(NREF)));

    // R5: a refresh is always followed by a NOP gap.
    a_r5_ref_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));

    // R6: mode load only after every refresh.
    a_r6_mrs_after_refs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (ref_cnt == RW'(NREF) && ba == 2'b00));

    // R8: ready is sticky and the bus idles on NOP.
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r8_done_nop: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PWR  = 20;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int TMRD = 2;
    localparam int NREF = 8;
    localparam int LOGN = 70;
    // Expected mode word: CL=3 -> bits 6:4 = 011, interleaved -> bit3 = 1, BL4 -> 010
    localparam logic [12:0] MODE_EXP = 13'h03A;
    localparam int K_PRE  = PWR;
    localparam int K_REF0 = PWR + TRP;
    localparam int K_MRS  = K_REF0 + (NREF - 1) * TRFC + TRFC;
    localparam int K_DONE = K_MRS + TMRD;

    // Vector table: cycle index, expected command, expected address, expected ready
    localparam int NV = 8;
    localparam int          V_K   [NV] = '{K_PRE, K_REF0, K_REF0 + TRFC, K_MRS - TRFC,
                                           K_MRS, K_DONE - 1, K_DONE, K_DONE + 3};
    localparam logic [3:0]  V_CMD [NV] = '{4'b0010, 4'b0001, 4'b0001, 4'b0001,
                                           4'b0000, 4'b0111, 4'b0111, 4'b0111};
    localparam logic [12:0] V_ADR [NV] = '{13'h400, 13'h0, 13'h0, 13'h0,
                                           MODE_EXP, 13'h0, 13'h0, 13'h0};
    localparam logic        V_DN  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_stable = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, dqm, init_done;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [3:0]  cmd_log  [LOGN];
    logic [12:0] addr_log [LOGN];
    logic [1:0]  ba_log   [LOGN];
    logic        done_log [LOGN];

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_init_seq #(
        .PWRUP_CYCLES(PWR), .TRP_CYCLES(TRP), .TRFC_CYCLES(TRFC), .TMRD_CYCLES(TMRD),
        .REFRESH_COUNT(NREF), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1), .CAS_LATENCY(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .dqm(dqm), .ba(ba), .addr(addr), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input int k);
        if (k < K_PRE) return 4'b0111;
        if (k == K_PRE) return 4'b0010;
        if (k >= K_REF0 && k < K_MRS && ((k - K_REF0) % TRFC) == 0) return 4'b0001;
        if (k == K_MRS) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic string tag_of(input int k);
        if (k < K_PRE) return "R2";
        if (k == K_PRE) return "R3";
        if (k < K_REF0) return "R4";
        if (k < K_MRS) return "R5";
        if (k == K_MRS) return "R6";
        return "R8";
    endfunction

    // Record the bus for LOGN cycles after the start edge; optionally drop clk_stable.
    task automatic capture(input int drop_at);
        for (int k = 0; k < LOGN; k++) begin
            @(negedge clk);
            cmd_log[k]  = {cs_n, ras_n, cas_n, we_n};
            addr_log[k] = addr;
            ba_log[k]   = ba;
            done_log[k] = init_done;
            if (k == drop_at) clk_stable = 1'b0;
        end
    endtask

    task automatic check_inhibit(input string req);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, req, {cs_n, ras_n, cas_n, we_n}, 4'hF);
        chk(cke && dqm, req, {cke, dqm}, 2'b11);
        chk(init_done == 1'b0, req, init_done, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clk_stable = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int mism;
        int nref;
        // R1: reset state and idle before clk_stable
        repeat (3) @(negedge clk);
        check_inhibit("R1");
        chk(addr == 13'h0, "R1", addr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_inhibit("R1");

        // Main run: full timeline
        clk_stable = 1'b1;
        capture(-1);
        for (int i = 0; i < NV; i++) begin
            chk(cmd_log[V_K[i]] == V_CMD[i], tag_of(V_K[i]), cmd_log[V_K[i]], V_CMD[i]);
            chk(addr_log[V_K[i]] == V_ADR[i], (V_CMD[i] == 4'b0000) ? "R7" : tag_of(V_K[i]),
                addr_log[V_K[i]], V_ADR[i]);
            chk(done_log[V_K[i]] == V_DN[i], "R8", done_log[V_K[i]], V_DN[i]);
        end
        nref = 0;
        for (int k = 0; k < LOGN; k++) begin
            chk(cmd_log[k] == exp_cmd(k), tag_of(k), cmd_log[k], exp_cmd(k));
            chk(ba_log[k] == 2'b00, "R6", ba_log[k], 0);
            if (cmd_log[k] == 4'b0001) nref++;
        end
        chk(nref == NREF, "R5", nref, NREF);
        chk(addr_log[K_MRS][2:0] == 3'b010 && addr_log[K_MRS][3] == 1'b1 &&
            addr_log[K_MRS][6:4] == 3'd3 && addr_log[K_MRS][12:7] == 6'd0,
            "R7", addr_log[K_MRS], MODE_EXP);
        repeat (10) @(negedge clk);
        chk(init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8",
            {init_done, cs_n, ras_n, cas_n, we_n}, 5'h17);

        // R9: clk_stable dropped mid-sequence has no effect
        do_reset();
        clk_stable = 1'b1;
        capture(5);
        mism = 0;
        for (int k = 0; k < LOGN; k++)
            if (cmd_log[k] != exp_cmd(k)) mism++;
        chk(mism == 0, "R9", mism, 0);
        chk(done_log[K_DONE] == 1'b1, "R9", done_log[K_DONE], 1);

        // R10: reset mid-sequence restarts from inhibit with the full wait
        do_reset();
        clk_stable = 1'b1;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        clk_stable = 1'b0;
        @(negedge clk);
        check_inhibit("R10");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_inhibit("R10");
        clk_stable = 1'b1;
        capture(-1);
        chk(cmd_log[K_PRE - 1] == 4'b0111, "R10", cmd_log[K_PRE - 1], 4'b0111);
        chk(cmd_log[K_PRE] == 4'b0010, "R10", cmd_log[K_PRE], 4'b0010);
        chk(done_log[K_DONE] == 1'b1, "R10", done_log[K_DONE], 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule